// File: doc/BRIEF.md
# Three-Wire Configuration Port for a Converter Register Map

This block lets a host read and write a small byte-wide register file over a three-wire serial link: a serial clock, an active-low select and one shared data pin. SCLK, CSB and the SDIO input are resampled in the block's own clock domain. Every transaction opens with a 16-bit instruction that carries the direction, the number of data bytes and a 13-bit start address. One or more data bytes follow. For a read, the block takes over the data pin and drives register contents back to the host.

Data bytes can move most-significant bit first, which is the reset default, or least-significant bit first. The order is chosen by a bit in the configuration register. In a multi-byte transfer the address steps by one after each byte. It steps down in the default order and up in the reversed order. Deasserting the select at any time ends the transfer, throws away any partly received byte and releases the data pin. All register contents are presented in parallel for the rest of the converter to use.

Top module: `cfgSpiSlave`

## Requirements
- R1: A transaction starts when csN falls. sdioIn is sampled on each rising sclk edge. The first 16 bits form the instruction and are always taken most-significant bit first: bit 15 is the direction (1 = read, 0 = write), bits 14:13 are the byte-count code, and bits 12:0 are the start address.
- R2: Byte-count codes 0, 1 and 2 move exactly 1, 2 and 3 data bytes. Any further sclk pulses before csN rises are ignored, so no register changes and no address step takes place.
- R3: Byte-count code 3 streams bytes, one after another, until csN rises.
- R4: A write byte is stored only after its eighth bit has been sampled. If csN rises earlier, the partial byte is discarded and no register changes.
- R5: In a read, sdioOe goes high on the first falling sclk edge after the instruction, and each new data bit appears on sdioOut after a falling sclk edge. sdioOe is low after reset and returns low within 3 clk cycles of csN going high.
- R6: Bit 0 of register 0 selects the data bit order: 0 = most-significant bit first, 1 = least-significant bit first. The order applies to data bytes only and is captured when csN falls.
- R7: After each data byte the address moves to the next register modulo 2^13. It decrements when the order is most-significant bit first and increments when it is least-significant bit first.
- R8: Reset loads register 0 with 0x00 and register i (i ≥ 1) with (0x11 × i) mod 256.
- R9: Bits 7:1 of register 0 always read as zero, whatever value is written to them. Writes to addresses at or above NUM_REGS change nothing, and reads from those addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; serial inputs are resampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low transaction select |
| sdioIn | input | 1 | Receive side of the shared data pin |
| sdioOut | output | 1 | Transmit side of the shared data pin |
| sdioOe | output | 1 | High while the block drives the shared data pin |
| regFlat | output | 8*NUM_REGS | All registers side by side; register i occupies bits 8i+7:8i |

## Verification
A table of writes with byte-count codes 0, 1 and 2 at scattered addresses is first written and then read back in most-significant-bit-first order. This exercises instruction decoding, downward address stepping and the read turnaround against a bench model. Further patterns separate the other cases:
- extra clocks after a counted transfer, which must be ignored;
- a streamed burst;
- a select withdrawn partway through a byte;
- writes and reads at unsupported addresses.

Asymmetric byte values in least-significant-bit-first mode tell a reversed bit order apart from a plain one and an upward address step apart from a downward one. Writing all ones to the configuration register shows that its open bits stay at zero.

// File: rtl/cfgSpiPkg.sv
package cfgSpiPkg;

  localparam int INSTR_W  = 16;
  localparam int ADDR_W   = INSTR_W - 3;
  localparam int BYTE_W   = 8;
  localparam int ORDER_BIT = 0;
  localparam logic [BYTE_W-1:0] CFG_MASK = 8'h01;

  typedef struct packed {
    logic shiftIn;   // capture one write bit
    logic commit;    // store the assembled byte
    logic outFirst;  // load a read byte and emit its first bit
    logic outNext;   // emit the next read bit
    logic oeOn;      // take the data pin
    logic oeOff;     // release the data pin
  } ctrlStrobe_t;

  function automatic logic [BYTE_W-1:0] regDefault(int idx);
    return (idx == 0) ? '0 : BYTE_W'(idx * 17);
  endfunction

endpackage

// File: rtl/cfgSpiSync.sv
module cfgSpiSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic csN,
  input  logic sdioIn,
  output logic sclkRise,
  output logic sclkFall,
  output logic csFall,
  output logic csIdle,
  output logic sdioBit
);

  logic [STAGES:0]   sclkPipe;
  logic [STAGES:0]   csPipe;
  logic [STAGES-1:0] sdioPipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclkPipe <= '0;
      csPipe   <= '1;
      sdioPipe <= '0;
    end else begin
      sclkPipe <= {sclkPipe[STAGES-1:0], sclk};
      csPipe   <= {csPipe[STAGES-1:0], csN};
      sdioPipe <= {sdioPipe[STAGES-2:0], sdioIn};
    end
  end

  assign sclkRise = sclkPipe[STAGES-1] & ~sclkPipe[STAGES];
  assign sclkFall = ~sclkPipe[STAGES-1] & sclkPipe[STAGES];
  assign csFall   = ~csPipe[STAGES-1] & csPipe[STAGES];
  assign csIdle   = csPipe[STAGES-1];
  assign sdioBit  = sdioPipe[STAGES-1];

endmodule

// File: rtl/cfgSpiCtrl.sv
module cfgSpiCtrl
  import cfgSpiPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sclkRise,
  input  logic              sclkFall,
  input  logic              csFall,
  input  logic              csIdle,
  input  logic              sdioBit,
  input  logic              cfgLsb,
  output ctrlStrobe_t       strobe,
  output logic [ADDR_W-1:0] curAddr,
  output logic              lsbMode
);

  typedef enum logic [1:0] {ST_IDLE, ST_INSTR, ST_DATA, ST_HOLD} state_t;

  state_t             state;
  logic [3:0]         instrCnt;
  logic [INSTR_W-2:0] instrShift;
  logic [2:0]         bitCnt;
  logic [1:0]         bytesLeft;
  logic               stream;
  logic               isRead;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      instrCnt   <= '0;
      instrShift <= '0;
      bitCnt     <= '0;
      bytesLeft  <= '0;
      stream     <= 1'b0;
      isRead     <= 1'b0;
      curAddr    <= '0;
      lsbMode    <= 1'b0;
    end else if (csIdle) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (csFall) begin
            state    <= ST_INSTR;
            instrCnt <= '0;
            lsbMode  <= cfgLsb;
          end
        end
        ST_INSTR: begin
          if (sclkRise) begin
            instrShift <= {instrShift[INSTR_W-3:0], sdioBit};
            instrCnt   <= instrCnt + 4'd1;
            if (instrCnt == 4'(INSTR_W - 1)) begin
              isRead    <= instrShift[INSTR_W-2];
              stream    <= &instrShift[INSTR_W-3:INSTR_W-4];
              bytesLeft <= instrShift[INSTR_W-3:INSTR_W-4];
              curAddr   <= {instrShift[ADDR_W-2:0], sdioBit};
              bitCnt    <= '0;
              state     <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (sclkRise) begin
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              curAddr <= lsbMode ? curAddr + 1'b1 : curAddr - 1'b1;
              if (!stream) begin
                if (bytesLeft == 2'd0) state <= ST_HOLD;
                else bytesLeft <= bytesLeft - 2'd1;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    if (csIdle) begin
      strobe.oeOff = 1'b1;
    end else if (state == ST_DATA) begin
      if (sclkRise && !isRead) begin
        strobe.shiftIn = 1'b1;
        strobe.commit  = (bitCnt == 3'd7);
      end
      if (sclkFall && isRead) begin
        strobe.oeOn     = 1'b1;
        strobe.outFirst = (bitCnt == 3'd0);
        strobe.outNext  = (bitCnt != 3'd0);
      end
    end
  end

endmodule

// File: rtl/cfgSpiData.sv
module cfgSpiData
  import cfgSpiPkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  ctrlStrobe_t                strobe,
  input  logic [ADDR_W-1:0]          curAddr,
  input  logic                       lsbMode,
  input  logic                       sdioBit,
  output logic                       sdioOut,
  output logic                       sdioOe,
  output logic                       cfgLsb,
  output logic [NUM_REGS*BYTE_W-1:0] regFlat
);

  localparam int IDX_W = $clog2(NUM_REGS);

  logic [BYTE_W-1:0] wrShift;
  logic [BYTE_W-1:0] wrByte;
  logic [BYTE_W-1:0] rdShift;
  logic [BYTE_W-1:0] rdByte;
  logic              inRange;

  assign wrByte  = lsbMode ? {sdioBit, wrShift[BYTE_W-1:1]}
                           : {wrShift[BYTE_W-2:0], sdioBit};
  assign inRange = curAddr < ADDR_W'(NUM_REGS);
  assign rdByte  = inRange ? regFlat[{curAddr[IDX_W-1:0], 3'b000} +: BYTE_W] : '0;
  assign cfgLsb  = regFlat[ORDER_BIT];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [BYTE_W-1:0] MASK = (i == 0) ? CFG_MASK : '1;
    logic [BYTE_W-1:0] value;
    always_ff @(posedge clk) begin
      if (rst) value <= regDefault(i);
      else if (strobe.commit && curAddr == ADDR_W'(i)) value <= wrByte & MASK;
    end
    assign regFlat[i*BYTE_W +: BYTE_W] = value;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrShift <= '0;
      rdShift <= '0;
      sdioOut <= 1'b0;
      sdioOe  <= 1'b0;
    end else begin
      if (strobe.shiftIn) wrShift <= wrByte;
      if (strobe.outFirst) begin
        sdioOut <= lsbMode ? rdByte[0] : rdByte[BYTE_W-1];
        rdShift <= lsbMode ? (rdByte >> 1) : (rdByte << 1);
      end else if (strobe.outNext) begin
        sdioOut <= lsbMode ? rdShift[0] : rdShift[BYTE_W-1];
        rdShift <= lsbMode ? (rdShift >> 1) : (rdShift << 1);
      end
      if (strobe.oeOff) sdioOe <= 1'b0;
      else if (strobe.oeOn) sdioOe <= 1'b1;
    end
  end

endmodule

// File: rtl/cfgSpiSlave.sv
module cfgSpiSlave
  import cfgSpiPkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sclk,
  input  logic                       csN,
  input  logic                       sdioIn,
  output logic                       sdioOut,
  output logic                       sdioOe,
  output logic [NUM_REGS*BYTE_W-1:0] regFlat
);

  logic              sclkRise, sclkFall, csFall, csIdle, sdioBit;
  logic              cfgLsb, lsbMode;
  logic [ADDR_W-1:0] curAddr;
  ctrlStrobe_t       strobe;

  cfgSpiSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk(sclk), .csN(csN), .sdioIn(sdioIn),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .csFall(csFall),
    .csIdle(csIdle), .sdioBit(sdioBit)
  );

  cfgSpiCtrl u_ctrl (
    .clk(clk), .rst(rst), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .csFall(csFall), .csIdle(csIdle), .sdioBit(sdioBit), .cfgLsb(cfgLsb),
    .strobe(strobe), .curAddr(curAddr), .lsbMode(lsbMode)
  );

  cfgSpiData #(.NUM_REGS(NUM_REGS)) u_data (
    .clk(clk), .rst(rst), .strobe(strobe), .curAddr(curAddr),
    .lsbMode(lsbMode), .sdioBit(sdioBit), .sdioOut(sdioOut),
    .sdioOe(sdioOe), .cfgLsb(cfgLsb), .regFlat(regFlat)
  );

endmodule

// File: rtl/cfgSpiSlaveChk.sv
module cfgSpiSlaveChk
  import cfgSpiPkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       sclk,
  input logic                       csN,
  input logic                       sdioOut,
  input logic                       sdioOe,
  input logic [NUM_REGS*BYTE_W-1:0] regFlat
);

  function automatic logic [NUM_REGS*BYTE_W-1:0] allDefaults();
    logic [NUM_REGS*BYTE_W-1:0] v;
    for (int i = 0; i < NUM_REGS; i++) v[i*BYTE_W +: BYTE_W] = regDefault(i);
    return v;
  endfunction

  // R8
  reset_defaults_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> regFlat == allDefaults());

  // R5
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    csN && $past(csN) && $past(csN, 2) && $past(csN, 3) |-> !sdioOe);

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sclk && $past(sclk) && $past(sclk, 2) && $past(sclk, 3) |-> $stable(sdioOut));

  // R9
  open_bits_chk: assert property (@(posedge clk) disable iff (rst)
    regFlat[BYTE_W-1:1] == '0);

  // R4
  idle_regs_chk: assert property (@(posedge clk) disable iff (rst)
    csN && $past(csN) && $past(csN, 2) && $past(csN, 3) |-> $stable(regFlat));

endmodule

bind cfgSpiSlave cfgSpiSlaveChk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst(rst), .sclk(sclk), .csN(csN),
  .sdioOut(sdioOut), .sdioOe(sdioOe), .regFlat(regFlat)
);

// File: tb/tb_cfgSpiSlave.sv
module tb_cfgSpiSlave;

  localparam int NREG = 8;
  localparam int HALF = 8;

  typedef struct packed {
    logic [1:0]  w;
    logic [12:0] addr;
    logic [23:0] data;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 13'd3, 24'h0000A5},
    '{2'd1, 13'd5, 24'h00C33C},
    '{2'd2, 13'd7, 24'h030201},
    '{2'd0, 13'd1, 24'h0000FF},
    '{2'd1, 13'd2, 24'h00965A},
    '{2'd0, 13'd6, 24'h000000}
  };

  logic clk = 0, rst = 1, sclk = 0, csN = 1, sdioIn = 0;
  logic sdioOut, sdioOe;
  logic [NREG*8-1:0] regFlat;

  int checks = 0, errors = 0, oeMiss = 0;
  logic [7:0] mdl [NREG];
  logic [7:0] txB [8];
  logic [7:0] rxB [8];

  always #2.5 clk = ~clk;

  cfgSpiSlave #(.NUM_REGS(NREG)) dut (
    .clk(clk), .rst(rst), .sclk(sclk), .csN(csN), .sdioIn(sdioIn),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .regFlat(regFlat)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic mdlReset();
    mdl[0] = 8'h00;
    for (int i = 1; i < NREG; i++) mdl[i] = 8'(i * 17);
  endtask

  task automatic mdlWrite(logic [12:0] a, logic [7:0] b);
    if (a < NREG) mdl[a] = (a == 0) ? (b & 8'h01) : b;
  endtask

  function automatic logic [7:0] mdlRead(logic [12:0] a);
    return (a < NREG) ? mdl[a] : 8'h00;
  endfunction

  function automatic logic [12:0] stepAddr(logic [12:0] a, logic lsb);
    return lsb ? a + 13'd1 : a - 13'd1;
  endfunction

  task automatic checkAll(string tag);
    for (int i = 0; i < NREG; i++)
      check($sformatf("%s reg%0d", tag, i), 32'(regFlat[i*8 +: 8]), 32'(mdl[i]));
  endtask

  task automatic halfWait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic clockBit(input logic b, output logic got);
    sdioIn = b;
    halfWait();
    got = sdioOut;
    sclk = 1;
    halfWait();
    sclk = 0;
  endtask

  task automatic spiXfer(input logic rd, input logic [1:0] w, input logic [12:0] addr,
                         input int nBits, input logic lsb);
    logic [15:0] instr;
    logic got;
    instr = {rd, w, addr};
    oeMiss = 0;
    csN = 0;
    halfWait();
    for (int i = 15; i >= 0; i--) clockBit(instr[i], got);
    if (rd) check("R5 oe low before first falling edge", 32'(sdioOe), 0);
    for (int k = 0; k < nBits; k++) begin
      int bi = k / 8;
      int bp = lsb ? (k % 8) : (7 - k % 8);
      clockBit(rd ? 1'b0 : txB[bi][bp], got);
      rxB[bi][bp] = got;
      if (rd && !sdioOe) oeMiss++;
    end
    halfWait();
    csN = 1;
    halfWait();
    check("R5 oe released after csN high", 32'(sdioOe), 0);
  endtask

  // Writes one transaction and updates the bench model.
  task automatic writeBytes(logic [1:0] w, logic [12:0] addr, int nb, logic lsb);
    logic [12:0] a = addr;
    for (int k = 0; k < nb; k++) begin
      mdlWrite(a, txB[k]);
      a = stepAddr(a, lsb);
    end
    spiXfer(1'b0, w, addr, nb * 8, lsb);
  endtask

  task automatic readCheck(string tag, logic [1:0] w, logic [12:0] addr, int nb, logic lsb);
    logic [12:0] a = addr;
    spiXfer(1'b1, w, addr, nb * 8, lsb);
    check({tag, " oe held during data"}, 32'(oeMiss), 0);
    for (int k = 0; k < nb; k++) begin
      check($sformatf("%s byte%0d", tag, k), 32'(rxB[k]), 32'(mdlRead(a)));
      a = stepAddr(a, lsb);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mdlReset();
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    checkAll("R8 reset");
    check("R5 oe after reset", 32'(sdioOe), 0);

    // R1 R2 R7: table of counted writes and read-backs, MSB-first
    for (int v = 0; v < 6; v++) begin
      int nb = int'(VECS[v].w) + 1;
      for (int k = 0; k < nb; k++) txB[k] = VECS[v].data[8*k +: 8];
      writeBytes(VECS[v].w, VECS[v].addr, nb, 1'b0);
      checkAll($sformatf("R1 R7 write vec%0d", v));
      readCheck($sformatf("R2 read vec%0d", v), VECS[v].w, VECS[v].addr, nb, 1'b0);
    end

    // R2: clocks past the counted byte are ignored
    txB[0] = 8'h5E; txB[1] = 8'hE7;
    mdlWrite(13'd6, 8'h5E);
    spiXfer(1'b0, 2'd0, 13'd6, 16, 1'b0);
    checkAll("R2 extra clocks");

    // R3: streaming write of 4 bytes and streaming read of 3
    txB[0] = 8'h10; txB[1] = 8'h20; txB[2] = 8'h30; txB[3] = 8'h40;
    writeBytes(2'd3, 13'd4, 4, 1'b0);
    checkAll("R3 stream write");
    readCheck("R3 stream read", 2'd3, 13'd2, 3, 1'b0);

    // R4: aborted write byte
    txB[0] = 8'hFF;
    spiXfer(1'b0, 2'd0, 13'd7, 5, 1'b0);
    checkAll("R4 abort write");
    spiXfer(1'b1, 2'd0, 13'd3, 4, 1'b0);
    checkAll("R4 abort read");

    // R9: unsupported address
    txB[0] = 8'h77;
    writeBytes(2'd0, 13'h0100, 1, 1'b0);
    checkAll("R9 unsupported write");
    readCheck("R9 unsupported read", 2'd0, 13'h0100, 1, 1'b0);

    // R6 R7: switch to LSB-first, asymmetric bytes, upward stepping
    txB[0] = 8'h01;
    writeBytes(2'd0, 13'd0, 1, 1'b0);
    checkAll("R6 select lsb");
    txB[0] = 8'h83; txB[1] = 8'h42;
    writeBytes(2'd1, 13'd3, 2, 1'b1);
    checkAll("R6 R7 lsb write");
    readCheck("R6 lsb read", 2'd1, 13'd3, 2, 1'b1);
    txB[0] = 8'hFF;
    writeBytes(2'd0, 13'd0, 1, 1'b1);
    checkAll("R9 open bits");
    txB[0] = 8'h00;
    writeBytes(2'd0, 13'd0, 1, 1'b1);
    checkAll("R6 back to msb");
    readCheck("R6 msb read", 2'd0, 13'd3, 1, 1'b0);

    // R8: reset restores defaults
    rst = 1;
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    mdlReset();
    checkAll("R8 reset again");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule